// File: doc/BRIEF.md
# Timebase and Watchdog Timer

This block is a 32-bit register-mapped peripheral on an AXI4-Lite slave port. It combines a free-running timebase counter with a two-stage watchdog. The timebase advances on every clock and can be read at any time. Each time it wraps from all ones to zero, it emits a one-cycle interrupt pulse.

The watchdog is armed by either of two enable bits, which sit in two different registers. Once armed, it measures a fixed period of 2^PERIOD_LOG2 clocks, counted from the last software restart. The first period that passes without a restart sets a pending bit, which drives the watchdog interrupt. A second period that passes while that bit is still set drives a reset output for RST_CYCLES clocks. When that pulse ends, the watchdog returns to its idle state, but a sticky flag still records that the reset happened.

A build-time choice decides whether software may switch the watchdog off again after enabling it. With LOCK_ON_ENABLE=1, writes that clear an enable bit are ignored until the block's own reset or the end of a watchdog reset pulse.

Top module: `tbwd_top`

## Requirements
- R1: After `aresetn` is low, `tb_irq`, `wd_irq` and `wd_rst` are low, and the registers at byte offsets 0x0 and 0x4 read 0.
- R2: The timebase advances by one every clock, wrapping at 2^CNT_W. A read of offset 0x8 returns the count held just before the clock edge that accepts the read. A restart sets the count to 0.
- R3: `tb_irq` is high for exactly one cycle, the cycle right after the timebase steps from all ones to zero.
- R4: The watchdog is active when bit 2 of offset 0x0 or bit 0 of offset 0x4 is 1. With both bits 0, no expiry is ever recorded.
- R5: While the watchdog is active, `wd_irq` rises 2^PERIOD_LOG2 cycles after the last restart, and bit 0 of offset 0x0 reads 1 from then on.
- R6: A write with bit 0 set to offset 0x0 is a restart. It clears the pending bit, `wd_irq` and the timebase.
- R7: If the pending bit is still set when the next period expires (2^(PERIOD_LOG2+1) cycles after the restart), `wd_rst` goes high for exactly RST_CYCLES cycles. `wd_irq` stays high for the whole pulse.
- R8: At the end of the reset pulse, both enable bits, the pending bit and the timebase return to 0. Bit 1 of offset 0x0 reads 1 from the start of the pulse until software writes 1 to that bit.
- R9: With LOCK_ON_ENABLE=1, once the watchdog is active, writes that would clear either enable bit are ignored until reset. With LOCK_ON_ENABLE=0, such writes take effect.
- R10: Every write and every read gets exactly one response, with status 0 (OKAY). A read of offset 0xC or of an address that is not word aligned returns 0.
- R11: A write with `s_wstrb[0]` = 0 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| aresetn | input | 1 | Active-low synchronous reset |
| s_awaddr | input | AW | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response status |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| s_araddr | input | AW | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response status |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data taken |
| tb_irq | output | 1 | Timebase wrap pulse |
| wd_irq | output | 1 | Watchdog first-stage interrupt |
| wd_rst | output | 1 | Watchdog reset pulse |

## Verification
The hardest state to reach from the ports is the reset pulse. It only appears after two whole periods with no restart, and it then undoes its own enables. The stimulus restarts the timebase so that the cycle of each expiry is known exactly. It then checks `wd_irq` and `wd_rst` on every cycle through both expiries and the pulse. After that it reads back the sticky flag and the cleared enables. Two copies of the design, one per enable policy, share the same bus traffic, so the ignored disable write shows up as a difference in their read data and interrupts.

// File: rtl/tbwd_pkg.sv
package tbwd_pkg;

  // Word index decoded from address bits [3:2]
  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_ENB   = 2'd1;
  localparam logic [1:0] SEL_COUNT = 2'd2;

  // Bit positions inside the control word at offset 0x0
  localparam int BIT_ARMED = 0;
  localparam int BIT_FLAG  = 1;
  localparam int BIT_ENA   = 2;

  // True when the low n bits of v are all ones (the last cycle of a period)
  function automatic logic low_bits_full(input logic [31:0] v, input int n);
    logic [31:0] mask;
    mask = (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    return (v & mask) == mask;
  endfunction

  // Assembles the control word read back at offset 0x0
  function automatic logic [31:0] ctrl_word(input logic armed, input logic flag,
                                            input logic ena);
    logic [31:0] w;
    w = '0;
    w[BIT_ARMED] = armed;
    w[BIT_FLAG]  = flag;
    w[BIT_ENA]   = ena;
    return w;
  endfunction

endpackage

// File: rtl/tbwd_timebase.sv
module tbwd_timebase #(
  parameter int CNT_W       = 32,
  parameter int PERIOD_LOG2 = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic             period_tick,
  output logic             tb_irq
);
  import tbwd_pkg::*;

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic wrap;

  assign wrap        = &count;
  assign period_tick = low_bits_full(32'(count), PERIOD_LOG2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      tb_irq <= 1'b0;
    end else begin
      count  <= clr ? '0 : count + ONE;
      tb_irq <= wrap & ~clr;
    end
  end

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> count == $past(count) + ONE);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);

  p_tb_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tb_irq |=> !tb_irq);

endmodule

// File: rtl/tbwd_guard.sv
module tbwd_guard #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_en,
  input  logic restart,
  input  logic period_tick,
  input  logic flag_clr,
  output logic armed,
  output logic wd_rst,
  output logic pulse_end,
  output logic rst_flag
);
  localparam int PW = $clog2(RST_CYCLES + 1);
  localparam logic [PW-1:0] P_LEN = PW'(RST_CYCLES);
  localparam logic [PW-1:0] P_ONE = PW'(1);

  logic [PW-1:0] pcnt;
  logic          pulsing;
  logic          expire;
  logic          bite;

  assign pulsing   = pcnt != '0;
  assign pulse_end = pcnt == P_ONE;
  assign expire    = wd_en & period_tick & ~pulsing & ~restart;
  assign bite      = expire & armed;
  assign wd_rst    = pulsing;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      pcnt     <= '0;
      rst_flag <= 1'b0;
    end else begin
      if (restart || pulse_end) armed <= 1'b0;
      else if (expire)          armed <= 1'b1;

      if (bite)         pcnt <= P_LEN;
      else if (pulsing) pcnt <= pcnt - P_ONE;

      if (bite)          rst_flag <= 1'b1;
      else if (flag_clr) rst_flag <= 1'b0;
    end
  end

  p_bite_after_bark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_rst) |-> $past(armed));

  p_pulse_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_rst) |-> $past(pulse_end));

  p_idle_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_en && !armed) |=> !armed);

  p_restart_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !armed);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_flag && !flag_clr) |=> rst_flag);

endmodule

// File: rtl/tbwd_regs.sv
module tbwd_regs #(
  parameter int AW             = 4,
  parameter int CNT_W          = 32,
  parameter bit LOCK_ON_ENABLE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    awaddr,
  input  logic             awvalid,
  output logic             awready,
  input  logic [31:0]      wdata,
  input  logic [3:0]       wstrb,
  input  logic             wvalid,
  output logic             wready,
  output logic [1:0]       bresp,
  output logic             bvalid,
  input  logic             bready,
  input  logic [AW-1:0]    araddr,
  input  logic             arvalid,
  output logic             arready,
  output logic [31:0]      rdata,
  output logic [1:0]       rresp,
  output logic             rvalid,
  input  logic             rready,
  input  logic [CNT_W-1:0] count,
  input  logic             armed,
  input  logic             rst_flag,
  input  logic             pulse_end,
  output logic             wd_en,
  output logic             restart,
  output logic             flag_clr
);
  import tbwd_pkg::*;

  logic       wr_fire, rd_fire;
  logic       w_aligned, r_aligned;
  logic [1:0] wsel, rsel;
  logic       ctrl_hit, enb_hit;
  logic       en_a, en_b, lock;
  logic [31:0] rd_mux;
  logic       unused_bits;

  assign unused_bits = ^{wdata[31:3], wstrb[3:1], awaddr, araddr};

  assign wr_fire = awvalid & wvalid & ~bvalid;
  assign awready = wr_fire;
  assign wready  = wr_fire;
  assign rd_fire = arvalid & ~rvalid;
  assign arready = ~rvalid;
  assign bresp   = 2'b00;
  assign rresp   = 2'b00;

  assign w_aligned = awaddr[1:0] == 2'b00;
  assign r_aligned = araddr[1:0] == 2'b00;
  assign wsel      = awaddr[3:2];
  assign rsel      = araddr[3:2];

  assign ctrl_hit = wr_fire & wstrb[0] & w_aligned & (wsel == SEL_CTRL);
  assign enb_hit  = wr_fire & wstrb[0] & w_aligned & (wsel == SEL_ENB);
  assign restart  = ctrl_hit & wdata[BIT_ARMED];
  assign flag_clr = ctrl_hit & wdata[BIT_FLAG];
  assign wd_en    = en_a | en_b;

  always_comb begin
    rd_mux = '0;
    if (r_aligned) begin
      unique case (rsel)
        SEL_CTRL:  rd_mux = ctrl_word(armed, rst_flag, en_a);
        SEL_ENB:   rd_mux = {31'b0, en_b};
        SEL_COUNT: rd_mux = 32'(count);
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_a   <= 1'b0;
      en_b   <= 1'b0;
      lock   <= 1'b0;
      bvalid <= 1'b0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      if (pulse_end)                                en_a <= 1'b0;
      else if (ctrl_hit && (wdata[BIT_ENA] || !lock)) en_a <= wdata[BIT_ENA];

      if (pulse_end)                          en_b <= 1'b0;
      else if (enb_hit && (wdata[0] || !lock)) en_b <= wdata[0];

      if (pulse_end)                      lock <= 1'b0;
      else if (LOCK_ON_ENABLE && wd_en)   lock <= 1'b1;

      if (wr_fire)     bvalid <= 1'b1;
      else if (bready) bvalid <= 1'b0;

      if (rd_fire) begin
        rvalid <= 1'b1;
        rdata  <= rd_mux;
      end else if (rready) begin
        rvalid <= 1'b0;
      end
    end
  end

  p_bresp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> bvalid);

  p_read_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && rready) |=> !rvalid);

  p_lock_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !pulse_end) |=> wd_en);

endmodule

// File: rtl/tbwd_top.sv
module tbwd_top #(
  parameter int AW             = 4,
  parameter int CNT_W          = 32,
  parameter int PERIOD_LOG2    = 16,
  parameter int RST_CYCLES     = 16,
  parameter bit LOCK_ON_ENABLE = 1'b0
) (
  input  logic          clk,
  input  logic          aresetn,
  input  logic [AW-1:0] s_awaddr,
  input  logic          s_awvalid,
  output logic          s_awready,
  input  logic [31:0]   s_wdata,
  input  logic [3:0]    s_wstrb,
  input  logic          s_wvalid,
  output logic          s_wready,
  output logic [1:0]    s_bresp,
  output logic          s_bvalid,
  input  logic          s_bready,
  input  logic [AW-1:0] s_araddr,
  input  logic          s_arvalid,
  output logic          s_arready,
  output logic [31:0]   s_rdata,
  output logic [1:0]    s_rresp,
  output logic          s_rvalid,
  input  logic          s_rready,
  output logic          tb_irq,
  output logic          wd_irq,
  output logic          wd_rst
);
  logic [CNT_W-1:0] count;
  logic period_tick, wd_en, restart, flag_clr;
  logic armed, pulse_end, rst_flag;
  logic tb_clr;

  assign tb_clr = restart | pulse_end;
  assign wd_irq = armed;

  tbwd_regs #(.AW(AW), .CNT_W(CNT_W), .LOCK_ON_ENABLE(LOCK_ON_ENABLE)) u_regs (
    .clk(clk), .rst_n(aresetn),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .count(count), .armed(armed), .rst_flag(rst_flag), .pulse_end(pulse_end),
    .wd_en(wd_en), .restart(restart), .flag_clr(flag_clr)
  );

  tbwd_timebase #(.CNT_W(CNT_W), .PERIOD_LOG2(PERIOD_LOG2)) u_timebase (
    .clk(clk), .rst_n(aresetn), .clr(tb_clr),
    .count(count), .period_tick(period_tick), .tb_irq(tb_irq)
  );

  tbwd_guard #(.RST_CYCLES(RST_CYCLES)) u_guard (
    .clk(clk), .rst_n(aresetn), .wd_en(wd_en), .restart(restart),
    .period_tick(period_tick), .flag_clr(flag_clr),
    .armed(armed), .wd_rst(wd_rst), .pulse_end(pulse_end), .rst_flag(rst_flag)
  );

  p_irq_before_rst_r7: assert property (@(posedge clk) disable iff (!aresetn)
    wd_rst |-> wd_irq);

endmodule

// File: tb/test_tbwd_top.sv
`timescale 1ns/1ps
module test_tbwd_top;
  localparam int CW  = 10;
  localparam int N   = 5;
  localparam int L   = 3;
  localparam int PER = 1 << N;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic aresetn;
  logic [3:0] awaddr, araddr;
  logic awvalid, wvalid, arvalid;
  logic [31:0] wdata;
  logic [3:0] wstrb;
  logic bready, rready;

  logic awr0, wr0, bv0, arr0, rv0, tbi0, wdi0, wdr0;
  logic awr1, wr1, bv1, arr1, rv1, tbi1, wdi1, wdr1;
  logic [1:0] br0, rr0, br1, rr1;
  logic [31:0] rd0, rd1;

  tbwd_top #(.AW(4), .CNT_W(CW), .PERIOD_LOG2(N), .RST_CYCLES(L), .LOCK_ON_ENABLE(1'b0)) i_tbwd_top (
    .clk(clk), .aresetn(aresetn),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awr0),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wr0),
    .s_bresp(br0), .s_bvalid(bv0), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arr0),
    .s_rdata(rd0), .s_rresp(rr0), .s_rvalid(rv0), .s_rready(rready),
    .tb_irq(tbi0), .wd_irq(wdi0), .wd_rst(wdr0));

  tbwd_top #(.AW(4), .CNT_W(CW), .PERIOD_LOG2(N), .RST_CYCLES(L), .LOCK_ON_ENABLE(1'b1)) i_tbwd_top_once (
    .clk(clk), .aresetn(aresetn),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awr1),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wr1),
    .s_bresp(br1), .s_bvalid(bv1), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arr1),
    .s_rdata(rd1), .s_rresp(rr1), .s_rvalid(rv1), .s_rready(rready),
    .tb_irq(tbi1), .wd_irq(wdi1), .wd_rst(wdr1));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s,
                        output int w);
    while (bv0) @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1'b1; wvalid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    w = cyc;
    awvalid = 1'b0; wvalid = 1'b0;
    chk("R10 write response", {bv0, bv1, br0, br1}, 6'b110000);
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] v0, output logic [31:0] v1,
                        output int r);
    while (rv0) @(negedge clk);
    araddr = a; arvalid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    r = cyc;
    arvalid = 1'b0;
    v0 = rd0; v1 = rd1;
    chk("R10 read response", {rv0, rv1, rr0, rr1}, 6'b110000);
  endtask

  task automatic wait_to(input int base, input int d);
    while (cyc - base < d) @(negedge clk);
  endtask

  task automatic do_reset();
    aresetn = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    aresetn = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v0, v1;
    int w, r;
    awaddr = '0; araddr = '0; awvalid = 0; wvalid = 0; arvalid = 0;
    wdata = '0; wstrb = '0; bready = 1'b1; rready = 1'b1;
    do_reset();

    // R1 reset state
    chk("R1 outputs", {tbi0, wdi0, wdr0, tbi1, wdi1, wdr1}, 6'b0);
    bus_rd(4'h0, v0, v1, r); chk("R1 ctrl", v0, 0); chk("R1 ctrl once", v1, 0);
    bus_rd(4'h4, v0, v1, r); chk("R1 enb", v0, 0); chk("R1 enb once", v1, 0);
    // R10 unmapped and misaligned
    bus_rd(4'hC, v0, v1, r); chk("R10 unmapped", v0, 0);
    bus_wr(4'h0, 32'h1, 4'hF, w);
    bus_rd(4'h9, v0, v1, r); chk("R10 misaligned", v0, 0);

    // R2 count sweep with growing gaps
    bus_wr(4'h0, 32'h1, 4'hF, w);
    for (int k = 0; k < 16; k++) begin
      repeat (k) @(negedge clk);
      bus_rd(4'h8, v0, v1, r);
      chk("R2 count", v0, (r - w - 1) % (1 << CW));
      chk("R2 count once", v1, (r - w - 1) % (1 << CW));
    end

    // R4 watchdog off: no expiry
    bus_wr(4'h0, 32'h1, 4'hF, w);
    for (int d = 1; d <= 3 * PER; d++) begin
      wait_to(w, d);
      chk("R4 disabled no irq", {wdi0, wdi1, wdr0, wdr1}, 4'b0);
    end

    // R3 rollover pulse
    bus_wr(4'h0, 32'h1, 4'hF, w);
    for (int d = 1; d <= (1 << CW) + 2; d++) begin
      wait_to(w, d);
      chk("R3 tb_irq", {tbi0, tbi1}, (d == (1 << CW)) ? 2'b11 : 2'b00);
    end

    // R6 timely restarts keep irq low
    bus_wr(4'h0, 32'h5, 4'hF, w);
    for (int i = 0; i < 6; i++) begin
      wait_to(w, PER - 2 - i);
      chk("R6 serviced no irq", {wdi0, wdi1}, 2'b00);
      bus_wr(4'h0, 32'h5, 4'hF, w);
    end
    // R5 first expiry
    wait_to(w, PER - 1);
    chk("R5 before expiry", {wdi0, wdi1}, 2'b00);
    wait_to(w, PER);
    chk("R5 at expiry", {wdi0, wdi1, wdr0, wdr1}, 4'b1100);
    bus_rd(4'h0, v0, v1, r);
    chk("R5 pending bit", v0, 32'h5); chk("R5 pending bit once", v1, 32'h5);
    // R6 restart clears
    bus_wr(4'h0, 32'h5, 4'hF, w);
    chk("R6 irq cleared", {wdi0, wdi1}, 2'b00);
    bus_rd(4'h0, v0, v1, r);
    chk("R6 pending cleared", v0, 32'h4); chk("R6 pending cleared once", v1, 32'h4);
    bus_rd(4'h8, v0, v1, r);
    chk("R6 count cleared", v0, r - w - 1);

    // R7 full timeout, cycle by cycle
    bus_wr(4'h0, 32'h5, 4'hF, w);
    for (int d = 0; d <= 2 * PER + L + 2; d++) begin
      logic ei, er;
      wait_to(w, d);
      ei = (d >= PER) && (d < 2 * PER + L);
      er = (d >= 2 * PER) && (d < 2 * PER + L);
      chk("R7 irq", {wdi0, wdi1}, {ei, ei});
      chk("R7 rst", {wdr0, wdr1}, {er, er});
    end
    // R8 state after pulse
    bus_rd(4'h0, v0, v1, r);
    chk("R8 flag kept, enable gone", v0, 32'h2); chk("R8 flag once", v1, 32'h2);
    bus_rd(4'h4, v0, v1, r); chk("R8 enb cleared", {v0[0], v1[0]}, 2'b00);
    bus_rd(4'h8, v0, v1, r);
    chk("R8 count restarted", v0, r - (w + 2 * PER + L) - 1);
    repeat (2 * PER) @(negedge clk);
    chk("R8 stays quiet", {wdi0, wdi1, wdr0, wdr1}, 4'b0);
    bus_wr(4'h0, 32'h2, 4'hF, w);
    bus_rd(4'h0, v0, v1, r); chk("R8 flag cleared", v0, 0); chk("R8 flag cleared once", v1, 0);

    // R4 enable via second register
    bus_wr(4'h4, 32'h1, 4'hF, w);
    bus_wr(4'h0, 32'h1, 4'hF, w);
    wait_to(w, PER - 1); chk("R4 enb before", {wdi0, wdi1}, 2'b00);
    wait_to(w, PER);     chk("R4 enb expiry", {wdi0, wdi1}, 2'b11);

    // R9 disable attempt
    bus_wr(4'h0, 32'h1, 4'hF, w);
    bus_wr(4'h4, 32'h0, 4'hF, r);
    bus_rd(4'h4, v0, v1, r);
    chk("R9 repeat mode disables", v0, 0);
    chk("R9 once mode ignores", v1, 1);
    wait_to(w, PER + 1);
    chk("R9 irq repeat", wdi0, 0);
    chk("R9 irq once", wdi1, 1);
    do_reset();
    chk("R1 outputs after reset", {wdi0, wdi1, wdr0, wdr1}, 4'b0);
    bus_rd(4'h4, v0, v1, r); chk("R9 reset unlocks", v1, 0);

    // R11 strobe gating
    bus_wr(4'h0, 32'h4, 4'h0, w);
    bus_rd(4'h0, v0, v1, r); chk("R11 ctrl unchanged", v0, 0); chk("R11 ctrl once", v1, 0);
    bus_wr(4'h4, 32'h1, 4'hE, w);
    bus_rd(4'h4, v0, v1, r); chk("R11 enb unchanged", v0, 0); chk("R11 enb once", v1, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule